// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two ALU operands comes from in the execute stage of a five-stage in-order pipeline. There are three sources. The first is the register-file value captured when the instruction left decode. The second is the ALU result of the instruction one step ahead, which sits in the execute/memory latch. The third is the writeback value of the instruction two steps ahead, which sits in the memory/writeback latch.

The block compares the two execute-stage source register numbers with the destination numbers of the two older stages. A match counts only when that stage really writes a register and its destination is not register 0. When both older stages match, the newer result wins. An instruction three steps ahead needs no bypass path, because the register file writes early in the cycle and reads late in it. A load result reaches its consumer through the writeback path once the hazard unit has inserted its one-cycle stall.

The block is purely combinational. It drives the 2-bit select codes and the operand values that the multiplexers pick with them.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 2'b10, and operand A is the execute/memory result, when that stage's write flag is 1, its destination is nonzero, and its destination equals source A.
- R2: Operand A select is 2'b01, and operand A is the writeback value, when the writeback stage's write flag is 1, its destination is nonzero and equals source A, and R1's condition does not hold.
- R3: When both older stages qualify for the same source, the execute/memory stage is selected (2'b10).
- R4: A stage whose write flag is 0 never causes forwarding, even when its destination matches.
- R5: A destination of register 0 never causes forwarding.
- R6: With no qualifying match, the select is 2'b00 and the operand is the register-file value. This covers a producer three or more instructions ahead.
- R7: Operand B follows the same rules using source B, independently of operand A.
- R8: The select code 2'b11 never appears, and each operand output always equals the source named by its select.
- R9: A load value held in the writeback stage reaches a dependent source through select 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | REG_W | Execute-stage source register for operand A |
| src_b | input | REG_W | Execute-stage source register for operand B |
| mem_dst | input | REG_W | Destination register in execute/memory latch |
| mem_we | input | 1 | Register-write flag of execute/memory latch |
| wb_dst | input | REG_W | Destination register in memory/writeback latch |
| wb_we | input | 1 | Register-write flag of memory/writeback latch |
| rf_a | input | DATA_W | Register-file value for operand A |
| rf_b | input | DATA_W | Register-file value for operand B |
| mem_res | input | DATA_W | ALU result held in execute/memory latch |
| wb_res | input | DATA_W | Writeback value held in memory/writeback latch |
| sel_a | output | 2 | Operand A select (00 file, 10 exec/mem, 01 writeback) |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the selects or operands. The bench changes inputs only just after a falling clock edge. It samples the outputs a quarter period later, after the combinational paths have settled and well before the next rising edge. The vector table sweeps single matches, double matches, disabled writes and register 0 for each operand. The directed tests then change only the data values and confirm that each operand follows its selected source.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_we,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_we,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] mem_res,
  input  logic [DATA_W-1:0] wb_res,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic mem_live, wb_live;
  assign mem_live = mem_we && (mem_dst != '0);
  assign wb_live  = wb_we  && (wb_dst  != '0);

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src);
    if (mem_live && mem_dst == src)    return SEL_MEM;
    else if (wb_live && wb_dst == src) return SEL_WB;
    else                               return SEL_RF;
  endfunction

  function automatic logic [DATA_W-1:0] route(input logic [1:0] s,
                                              input logic [DATA_W-1:0] rf);
    case (s)
      SEL_MEM: return mem_res;
      SEL_WB:  return wb_res;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(src_a);
  assign sel_b  = pick(src_b);
  assign opnd_a = route(sel_a, rf_a);
  assign opnd_b = route(sel_b, rf_b);
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  src_b,
  input logic [REG_W-1:0]  mem_dst,
  input logic              mem_we,
  input logic [REG_W-1:0]  wb_dst,
  input logic              wb_we,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [DATA_W-1:0] mem_res,
  input logic [DATA_W-1:0] wb_res,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  always_comb begin
    if (sel_a == 2'b10) AST_A_MEM_SRC: assert (mem_we && mem_dst != '0 && mem_dst == src_a); // R1
    if (sel_a == 2'b01) AST_A_WB_SRC: assert (wb_we && wb_dst != '0 && wb_dst == src_a); // R2
    if (mem_we && mem_dst != '0 && mem_dst == src_a) AST_A_MEM_WINS: assert (sel_a == 2'b10); // R3
    if (!mem_we && !wb_we) AST_NO_WRITE_NO_FWD: assert (sel_a == 2'b00 && sel_b == 2'b00); // R4
    if (src_a == '0) AST_ZERO_A_FROM_RF: assert (sel_a == 2'b00); // R5
    if (src_b == '0) AST_ZERO_B_FROM_RF: assert (sel_b == 2'b00); // R5
    if (mem_we && mem_dst != '0 && mem_dst == src_b) AST_B_MEM_WINS: assert (sel_b == 2'b10); // R7
    if (sel_b == 2'b01) AST_B_WB_SRC: assert (wb_we && wb_dst != '0 && wb_dst == src_b); // R7
    AST_NO_SEL_11: assert (sel_a != 2'b11 && sel_b != 2'b11); // R8
    if (sel_a == 2'b00) AST_A_RF_DATA: assert (opnd_a == rf_a); // R8
    if (sel_b == 2'b01) AST_B_WB_DATA: assert (opnd_b == wb_res); // R8
    if (sel_a == 2'b10) AST_A_MEM_DATA: assert (opnd_a == mem_res); // R8
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  localparam int  REG_W  = 5;
  localparam int  DATA_W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [REG_W-1:0]  src_a, src_b, mem_dst, wb_dst;
  logic              mem_we, wb_we;
  logic [DATA_W-1:0] rf_a, rf_b, mem_res, wb_res, opnd_a, opnd_b;
  logic [1:0]        sel_a, sel_b;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fwd_unit (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // fields: src_a, src_b, mem_dst, mem_we, wb_dst, wb_we, exp sel_a, exp sel_b
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00}, // R6
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // R1
    {5'd3,  5'd4,  5'd9,  1'b1, 5'd3,  1'b1, 2'b01, 2'b00}, // R2
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10}, // R3
    {5'd6,  5'd7,  5'd6,  1'b0, 5'd7,  1'b0, 2'b00, 2'b00}, // R4
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
    {5'd8,  5'd9,  5'd9,  1'b1, 5'd8,  1'b1, 2'b01, 2'b10}, // R7
    {5'd10, 5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 2'b01, 2'b01}, // R9
    {5'd12, 5'd13, 5'd12, 1'b0, 5'd12, 1'b1, 2'b01, 2'b00}, // R4
    {5'd0,  5'd15, 5'd0,  1'b1, 5'd15, 1'b1, 2'b00, 2'b01}, // R5
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 2'b10, 2'b10}  // R3
  };

  function automatic logic [DATA_W-1:0] exp_data(input logic [1:0] s,
                                                 input logic [DATA_W-1:0] rf);
    return (s == 2'b10) ? mem_res : (s == 2'b01) ? wb_res : rf;
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    @(negedge clk);
    {src_a, src_b, mem_dst, mem_we, wb_dst, wb_we} = v[25:4];
    #(CLK_PERIOD/4);
  endtask

  initial begin
    src_a = '0; src_b = '0; mem_dst = '0; wb_dst = '0;
    mem_we = 1'b0; wb_we = 1'b0;
    rf_a = 32'hA1A1_0001; rf_b = 32'hB2B2_0002;
    mem_res = 32'hC3C3_0003; wb_res = 32'hD4D4_0004;
    #(CLK_PERIOD/4);
    chk("R6 idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R6 idle opnd_b", opnd_b, rf_b);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      chk("R1/R2/R3/R4/R5/R6/R9 sel_a", {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      chk("R7 sel_b", {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      chk("R8 opnd_a", opnd_a, exp_data(VEC[i][3:2], rf_a));
      chk("R8 opnd_b", opnd_b, exp_data(VEC[i][1:0], rf_b));
    end

    // R8: data tracks the selected source with selects held
    drive({5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 4'b0});
    @(negedge clk);
    mem_res = 32'h1234_5678; wb_res = 32'h8765_4321; rf_a = 32'h0;
    #(CLK_PERIOD/4);
    chk("R8 opnd_a follows mem_res", opnd_a, 32'h1234_5678);
    chk("R8 opnd_b follows wb_res", opnd_b, 32'h8765_4321);

    // R9: load value in writeback reaches both sources
    @(negedge clk);
    src_a = 5'd20; src_b = 5'd20; mem_dst = 5'd21; mem_we = 1'b1;
    wb_dst = 5'd20; wb_we = 1'b1; wb_res = 32'hFEED_0BAD;
    #(CLK_PERIOD/4);
    chk("R9 load opnd_a", opnd_a, 32'hFEED_0BAD);
    chk("R9 load opnd_b", opnd_b, 32'hFEED_0BAD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule